// File: doc/BRIEF.md
# Masked Interrupt Collector with Pending Register

This block gathers a parameterised set of interrupt lines (32 by default) into one request towards a processor core. Each line owns one bit in an enable-mask word and one bit in a pending word, with line n at bit n of both. A small register port lets software read either word, replace the mask with a full read-modify-write, and retire pending bits. The core's request is asserted when any pending line is also enabled.

Each line is built either as a rising-edge line or as a level line, chosen per bit by a parameter. A second parameter picks one of two retire conventions. In the standard build, a one written to the pending word retires that bit, and a level line's pending bit is the line's level. In the alternate build, a zero written retires the bit, and level lines are captured and stay pending until software retires them. Software scans the pending word from bit 0 upward and services each set bit in turn.

Top module: `intc_top`

## Requirements
- R1: While reset is active, and right after it, the mask word, the pending word and `cpu_irq` are all zero. Every line is disabled until software writes the mask.
- R2: `reg_sel` = 0 addresses the mask word and `reg_sel` = 1 addresses the pending word. A write with `reg_sel` = 0 replaces the whole mask at the clock edge. `reg_rdata` shows the addressed word combinationally.
- R3: `cpu_irq` is registered. After each edge it equals the OR of (pending AND mask) as it stood before that edge.
- R4: On an edge line (bit set in `EDGE_SEL`, default lines 0 to 15), a 0-to-1 change of the input between two clock edges sets the pending bit at the second edge. A line held high after its bit is retired does not set it again.
- R5: In the standard build (`ZERO_CLEARS` = 0), a pending-word write retires each edge bit written as 1. Bits written as 0 keep their value.
- R6: In the alternate build (`ZERO_CLEARS` = 1), a pending-word write retires each bit written as 0. Bits written as 1 keep their value.
- R7: When a new rising edge and a retiring write hit the same bit at the same edge, the bit stays set.
- R8: In the standard build, a level line's pending bit equals the line's level one edge later. Writes to the pending word have no effect on it.
- R9: In the alternate build, a level line's pending bit sets while the line is high and stays set after the line falls, until a retiring write. If the line is still high when the write arrives, the bit sets again.
- R10: The mask gates only `cpu_irq`. Disabled lines still become pending and read back as pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Interrupt lines, line n at bit n |
| reg_sel | input | 1 | Word select: 0 mask, 1 pending |
| reg_we | input | 1 | Write strobe for the selected word |
| reg_wdata | input | N_LINES | Write data |
| reg_rdata | output | N_LINES | Selected word, combinational |
| cpu_irq | output | 1 | Registered request to the core |

## Verification
The embedded properties check the following on every cycle:
- the request equals the previous cycle's enabled-and-pending OR;
- a detected edge always lands in the pending word;
- a retire that does not collide with a set empties the bit;
- sticky bits never change without a set or a retire;
- in the standard build, level bits follow the input;
- a mask write lands in the mask.

Only the bench's scenarios can show the following:
- the word selection on the read path;
- that the two retire polarities really differ for the same written word;
- that a held-high line does not set again;
- that masked lines still become pending.

Both builds run side by side on identical stimulus.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int MAXW = 64;
  typedef logic [MAXW-1:0] vec_t;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_PEND = 1'b1
  } reg_sel_e;

  // Bits retired by a pending-word write under the chosen polarity.
  function automatic vec_t retire_bits(input logic wr, input vec_t wdata,
                                       input logic zero_clears);
    if (!wr) return '0;
    return zero_clears ? ~wdata : wdata;
  endfunction

  // Sticky update: a set always beats a retire.
  function automatic vec_t sticky_next(input vec_t set_v, input vec_t cur,
                                       input vec_t retire);
    return set_v | (cur & ~retire);
  endfunction

endpackage

// File: rtl/intc_rise_det.sv
module intc_rise_det #(
  parameter int                 N_LINES  = 32,
  parameter logic [N_LINES-1:0] EDGE_SEL = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  output logic [N_LINES-1:0] rise
);

  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  assign rise = irq_in & ~prev_q & EDGE_SEL;

endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank
  import intc_pkg::*;
#(
  parameter int                 N_LINES     = 32,
  parameter logic [N_LINES-1:0] EDGE_SEL    = '1,
  parameter bit                 ZERO_CLEARS = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [N_LINES-1:0] rise,
  input  logic [N_LINES-1:0] retire,
  output logic [N_LINES-1:0] pend_q
);

  // Level lines are captured only in the alternate build.
  localparam logic [N_LINES-1:0] LVL_LATCH = ZERO_CLEARS ? ~EDGE_SEL : '0;
  localparam logic [N_LINES-1:0] STICKY_M  = EDGE_SEL | LVL_LATCH;

  logic [N_LINES-1:0] set_v;
  logic [N_LINES-1:0] sticky_v;
  logic [N_LINES-1:0] pend_d;

  assign set_v    = rise | (irq_in & LVL_LATCH);
  assign sticky_v = N_LINES'(sticky_next(vec_t'(set_v), vec_t'(pend_q),
                                         vec_t'(retire)));

  for (genvar i = 0; i < N_LINES; i++) begin : g_bit
    if (STICKY_M[i]) begin : g_sticky
      assign pend_d[i] = sticky_v[i];
    end else begin : g_follow
      assign pend_d[i] = irq_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R4, R7: a detected edge is never lost, even against a retire.
  a_r4_edge_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R5, R6: a retire with no competing set empties the bit.
  a_r5_retire_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ((retire & ~set_v & STICKY_M) != '0) |=>
      ((pend_q & $past(retire & ~set_v & STICKY_M)) == '0));

  // R9: sticky bits move only on a set or a retire.
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_q ^ $past(pend_q)) &
               $past(STICKY_M & ~set_v & ~retire)) == '0));

  if (!ZERO_CLEARS) begin : g_lvl_chk
    // R8: standard level bits track the input one edge later.
    a_r8_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pend_q ^ $past(irq_in)) & ~EDGE_SEL) == '0));
  end

endmodule

// File: rtl/intc_req.sv
module intc_req #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pend_q,
  input  logic [N_LINES-1:0] mask_q,
  output logic               cpu_irq
);

  logic [N_LINES-1:0] hit;

  assign hit = pend_q & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= |hit;
  end

  // R3: request follows the previous cycle's enabled pending set.
  a_r3_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == (|$past(hit))));

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int                 N_LINES     = 32,
  parameter logic [N_LINES-1:0] EDGE_SEL    = N_LINES'(32'h0000_FFFF),
  parameter bit                 ZERO_CLEARS = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               cpu_irq
);

  reg_sel_e           sel;
  logic               mask_wr;
  logic               pend_wr;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] retire;

  assign sel     = reg_sel_e'(reg_sel);
  assign mask_wr = reg_we && (sel == SEL_MASK);
  assign pend_wr = reg_we && (sel == SEL_PEND);
  assign retire  = N_LINES'(retire_bits(pend_wr, vec_t'(reg_wdata),
                                        ZERO_CLEARS));

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata;
  end

  assign reg_rdata = (sel == SEL_PEND) ? pend_q : mask_q;

  intc_rise_det #(.N_LINES(N_LINES), .EDGE_SEL(EDGE_SEL)) u_rise (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
  );

  intc_pend_bank #(.N_LINES(N_LINES), .EDGE_SEL(EDGE_SEL),
                   .ZERO_CLEARS(ZERO_CLEARS)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise),
    .retire(retire), .pend_q(pend_q)
  );

  intc_req #(.N_LINES(N_LINES)) u_req (
    .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .mask_q(mask_q),
    .cpu_irq(cpu_irq)
  );

  // R2: a mask write lands in the mask word.
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(reg_wdata)));

endmodule

// File: tb/intc_top_tb_top.sv
module intc_top_tb_top;

  localparam int          N    = 32;
  localparam logic [31:0] EDGE = 32'h0000_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] lines = '0, wd = '0;
  logic        we = 1'b0, ad = 1'b0;
  logic [31:0] rd_s, rd_v;
  logic        irq_s, irq_v;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  intc_top #(.N_LINES(N), .EDGE_SEL(EDGE), .ZERO_CLEARS(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(lines), .reg_sel(ad), .reg_we(we),
    .reg_wdata(wd), .reg_rdata(rd_s), .cpu_irq(irq_s));

  intc_top #(.N_LINES(N), .EDGE_SEL(EDGE), .ZERO_CLEARS(1'b1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .irq_in(lines), .reg_sel(ad), .reg_we(we),
    .reg_wdata(wd), .reg_rdata(rd_v), .cpu_irq(irq_v));

  logic [31:0] m_st [2];
  logic [31:0] m_mk [2];
  logic        m_irq [2];
  logic [31:0] m_prev;

  function automatic logic [31:0] exp_pend(input logic [31:0] st,
      input logic [31:0] ln, input logic [31:0] prev, input logic w,
      input logic a, input logic [31:0] d, input logic zc);
    logic [31:0] kill, edge_part, lvl;
    kill      = (w && a) ? (zc ? ~d : d) : 32'h0;
    edge_part = (ln & ~prev) | (st & ~kill);
    lvl       = zc ? (ln | (st & ~kill)) : ln;
    return (edge_part & EDGE) | (lvl & ~EDGE);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string what, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(rd_s, ad ? m_st[0] : m_mk[0], "std rdata", tag);
    chk(rd_v, ad ? m_st[1] : m_mk[1], "alt rdata", tag);
    chk({31'h0, irq_s}, {31'h0, m_irq[0]}, "std cpu_irq", tag);
    chk({31'h0, irq_v}, {31'h0, m_irq[1]}, "alt cpu_irq", tag);
  endtask

  // Apply at a negedge, advance the model, check at the next negedge.
  task automatic step(input logic [31:0] ln, input logic w, input logic a,
                      input logic [31:0] d, input string tag);
    lines = ln; we = w; ad = a; wd = d;
    for (int v = 0; v < 2; v++) begin
      m_irq[v] = |(m_st[v] & m_mk[v]);
      m_st[v]  = exp_pend(m_st[v], ln, m_prev, w, a, d, logic'(v));
      if (w && !a) m_mk[v] = d;
    end
    m_prev = ln;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int v = 0; v < 2; v++) begin
      m_st[v] = '0; m_mk[v] = '0; m_irq[v] = 1'b0;
    end
    m_prev = '0;
    repeat (3) @(negedge clk);
    ad = 1'b0; #1; compare("R1 reset mask");
    ad = 1'b1; #1; compare("R1 reset pend");
    rst_n = 1'b1;

    step(32'h0, 1'b0, 1'b1, 32'h0, "R1 after reset");
    // R2: mask write and readback
    step(32'h0, 1'b1, 1'b0, 32'hA5A5_F00F, "R2 mask write");
    step(32'h0, 1'b0, 1'b0, 32'h0, "R2 mask read");
    step(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R2 mask all");
    // R4 + R3: pulse edge line 3
    step(32'h8, 1'b0, 1'b1, 32'h0, "R4 edge set");
    step(32'h8, 1'b0, 1'b1, 32'h0, "R3 request");
    // R5/R6: retire bit 3 (standard writes 1, alternate keeps on 1)
    step(32'h8, 1'b1, 1'b1, 32'h8, "R5 write one");
    step(32'h8, 1'b0, 1'b1, 32'h0, "R4 held no reset");
    step(32'h0, 1'b1, 1'b1, 32'hFFFF_FFF7, "R6 write zero");
    step(32'h0, 1'b0, 1'b1, 32'h0, "R6 readback");
    // R7: new edge on line 5 against a full retire under both polarities
    step(32'h20, 1'b1, 1'b1, 32'hFFFF_FFFF, "R7 edge vs one");
    step(32'h0, 1'b0, 1'b1, 32'h0, "R7 idle");
    step(32'h0, 1'b1, 1'b1, 32'h0, "R6 retire all");
    step(32'h20, 1'b1, 1'b1, 32'h0, "R7 edge vs zero");
    step(32'h0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R5 retire all");
    // R8/R9: level line 20
    step(32'h0010_0000, 1'b0, 1'b1, 32'h0, "R8 level rise");
    step(32'h0010_0000, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8 write ignored");
    step(32'h0, 1'b0, 1'b1, 32'h0, "R9 level held");
    step(32'h0, 1'b0, 1'b1, 32'h0, "R9 still held");
    step(32'h0010_0000, 1'b1, 1'b1, 32'h0, "R9 retire while high");
    step(32'h0, 1'b1, 1'b1, 32'h0, "R9 retire low");
    step(32'h0, 1'b0, 1'b1, 32'h0, "R9 empty");
    // R10: masked lines still pend
    step(32'h0, 1'b1, 1'b0, 32'h0, "R10 mask off");
    step(32'h0002_0002, 1'b0, 1'b1, 32'h0, "R10 pend masked");
    step(32'h0002_0002, 1'b0, 1'b1, 32'h0, "R10 no request");
    step(32'h0, 1'b1, 1'b0, 32'h0000_0002, "R10 enable line 1");
    step(32'h0, 1'b0, 1'b1, 32'h0, "R10 request on");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] ln;
      ln = m_prev ^ ($urandom & $urandom & $urandom);
      step(ln, ($urandom % 4) == 0, $urandom % 2, $urandom,
           "random R2 R3 R4 R5 R6 R7 R8 R9");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule